// File: doc/BRIEF.md
# Main-Set PWM Dimming Gate with Low-Level Shutdown

This block sits between the backlight control registers and the main LED current sinks. When PWM dimming is enabled, it switches the main set's current-enable on and off with an external, already synchronized dimming input. The average main current is therefore the programmed step current times the duty cycle of that input. The sub LED set is passed through untouched. Until the first rising edge of the dimming input arrives after dimming is enabled, the main set stays dark.

The block times every high and low phase of the dimming input in ticks of a prescaled clock. The default prescaler makes one tick every half microsecond. A high phase that is too short, or a low phase that is too short, raises a sticky violation flag. So does a low phase that outlasts the dimming window but ends before the shutdown delay. A low level held for the full shutdown delay is not treated as 0% duty. Instead it raises a shutdown flag that keeps the main set off. The next rising edge clears the flag and resumes gating.

Top module: `pwm_dim_gate`

## Requirements
- R1: With `pwm_en` low, `main_on` equals `main_req` of the previous clock cycle whatever `pwm_in` does, and no pulse is judged.
- R2: `sub_on` always equals `sub_req` of the previous cycle, independent of `pwm_in`, `pwm_en` and `shutdown`.
- R3: With `pwm_en` high and the gate armed, `main_on` equals `main_req AND pwm_in AND NOT shutdown` of the previous cycle.
- R4: After `pwm_en` is set, the gate arms only on a 0-to-1 transition of `pwm_in` sampled while `pwm_en` is high. A level that was already high is not such a transition, and `main_on` stays 0 until the gate arms.
- R5: Clearing `pwm_en` disarms the gate and clears `shutdown` in the following cycle.
- R6: A phase that lasts N clock cycles measures floor(N / TICK_DIV) ticks, and timing restarts at every edge of `pwm_in`.
- R7: A high phase, started while armed, that measures fewer than HIGH_MIN_TICKS ticks sets `violation` one cycle after its falling edge.
- R8: A low phase, started while armed and ending in a rising edge before shutdown, sets `violation` when it measures fewer than LOW_MIN_TICKS ticks or more than LOW_MAX_TICKS ticks.
- R9: While armed, `pwm_in` held low for SHDN_TICKS × TICK_DIV cycles sets `shutdown`, and `main_on` is 0 while `shutdown` is 1. One cycle less does not set `shutdown`.
- R10: A rising edge of `pwm_in` clears `shutdown` and resumes gating in the next cycle, and the low phase that caused the shutdown is not a violation.
- R11: `violation` stays set until reset. Phases that began before the gate armed are never judged.
- R12: During and after reset, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_en | input | 1 | Dimming-enable register bit |
| main_req | input | 1 | Main set turned on by its register |
| sub_req | input | 1 | Sub set turned on by its register |
| pwm_in | input | 1 | Synchronized dimming input |
| main_on | output | 1 | Main set current-enable after gating |
| sub_on | output | 1 | Sub set current-enable, never gated |
| shutdown | output | 1 | Dimming input low beyond the shutdown delay |
| violation | output | 1 | Sticky flag for a pulse outside the timing limits |

## Verification
Pulse trains are applied with phases that sit exactly on each threshold and one cycle either side of it: the shortest valid high, the shortest and longest valid low, and one cycle short of the shutdown delay. These show whether the tick counting truncates correctly and whether timing restarts at each edge. Enabling dimming while the input is already high, and dropping dimming in the middle of a shutdown, separate edge-based arming from level-based arming. Random pulse trains with random register bits then mix gated, bypassed and shut-down cycles. The expected value of each output is predicted from phase lengths alone.

// File: rtl/pwmdim_pkg.sv
package pwmdim_pkg;

    typedef struct packed {
        logic live;     // at least one clock edge seen since reset
        logic armed;    // rising edge seen while dimming enabled
        logic shdn;     // low level outlasted the shutdown delay
        logic viol;     // sticky timing violation
        logic main_on;  // gated main-set enable
        logic sub_on;   // ungated sub-set enable
    } ctl_t;

    localparam ctl_t CTL_RESET = '{default: 1'b0};

endpackage

// File: rtl/pwmdim_phase_timer.sv
module pwmdim_phase_timer #(
    parameter  int TICK_DIV  = 100,
    parameter  int SAT_TICKS = 32000,
    localparam int PRE_W     = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1,
    localparam int DUR_W     = $clog2(SAT_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_in,
    output logic             rise,
    output logic             fall,
    output logic [DUR_W-1:0] ended_ticks,
    output logic [DUR_W-1:0] run_ticks
);

    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
    localparam logic [DUR_W-1:0] DUR_SAT  = DUR_W'(SAT_TICKS);

    typedef struct packed {
        logic             lvl;
        logic [PRE_W-1:0] pre;
        logic [DUR_W-1:0] dur;
    } tmr_t;

    tmr_t t_d, t_q;
    logic [PRE_W-1:0] base_pre;
    logic [DUR_W-1:0] base_dur;

    always_comb begin
        rise     = pwm_in & ~t_q.lvl;
        fall     = ~pwm_in & t_q.lvl;
        base_pre = (rise | fall) ? '0 : t_q.pre;
        base_dur = (rise | fall) ? '0 : t_q.dur;
        t_d.lvl  = pwm_in;
        if (base_pre == PRE_LAST) begin
            t_d.pre = '0;
            t_d.dur = (base_dur == DUR_SAT) ? base_dur : base_dur + 1'b1;
        end else begin
            t_d.pre = base_pre + 1'b1;
            t_d.dur = base_dur;
        end
        ended_ticks = t_q.dur;
        run_ticks   = t_d.dur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.lvl <= 1'b1;
            t_q.pre <= '0;
            t_q.dur <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    // R6: the tick count never passes its saturation value
    assert_ticks_capped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.dur <= DUR_SAT);

endmodule

// File: rtl/pwmdim_pulse_judge.sv
module pwmdim_pulse_judge #(
    parameter int HIGH_MIN_TICKS = 1,
    parameter int LOW_MIN_TICKS  = 1,
    parameter int LOW_MAX_TICKS  = 1000,
    parameter int DUR_W          = 15
) (
    input  logic             en,
    input  logic             armed,
    input  logic             shdn,
    input  logic             rise,
    input  logic             fall,
    input  logic [DUR_W-1:0] ended_ticks,
    output logic             bad_pulse
);

    localparam logic [DUR_W-1:0] HI_MIN = DUR_W'(HIGH_MIN_TICKS);
    localparam logic [DUR_W-1:0] LO_MIN = DUR_W'(LOW_MIN_TICKS);
    localparam logic [DUR_W-1:0] LO_MAX = DUR_W'(LOW_MAX_TICKS);

    logic high_short;
    logic low_out;

    always_comb begin
        high_short = ended_ticks < HI_MIN;
        low_out    = (ended_ticks < LO_MIN) || (ended_ticks > LO_MAX);
        bad_pulse  = en & armed &
                     ((fall & high_short) | (rise & ~shdn & low_out));
    end

endmodule

// File: rtl/pwmdim_gate.sv
module pwmdim_gate (
    input  logic main_req,
    input  logic pwm_en,
    input  logic armed,
    input  logic level,
    input  logic shdn,
    output logic main_on_next
);

    always_comb begin
        if (pwm_en) main_on_next = main_req & armed & level & ~shdn;
        else        main_on_next = main_req;
    end

endmodule

// File: rtl/pwm_dim_gate.sv
module pwm_dim_gate
    import pwmdim_pkg::*;
#(
    parameter int TICK_DIV       = 100,
    parameter int HIGH_MIN_TICKS = 1,
    parameter int LOW_MIN_TICKS  = 1,
    parameter int LOW_MAX_TICKS  = 1000,
    parameter int SHDN_TICKS     = 32000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_en,
    input  logic main_req,
    input  logic sub_req,
    input  logic pwm_in,
    output logic main_on,
    output logic sub_on,
    output logic shutdown,
    output logic violation
);

    localparam int DUR_W = $clog2(SHDN_TICKS + 1);
    localparam logic [DUR_W-1:0] SHDN_LIM = DUR_W'(SHDN_TICKS);

    ctl_t s_d, s_q;
    logic             rise, fall;
    logic [DUR_W-1:0] ended_ticks, run_ticks;
    logic             bad_pulse;
    logic             main_on_next;

    pwmdim_phase_timer #(
        .TICK_DIV  (TICK_DIV),
        .SAT_TICKS (SHDN_TICKS)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwm_in      (pwm_in),
        .rise        (rise),
        .fall        (fall),
        .ended_ticks (ended_ticks),
        .run_ticks   (run_ticks)
    );

    pwmdim_pulse_judge #(
        .HIGH_MIN_TICKS (HIGH_MIN_TICKS),
        .LOW_MIN_TICKS  (LOW_MIN_TICKS),
        .LOW_MAX_TICKS  (LOW_MAX_TICKS),
        .DUR_W          (DUR_W)
    ) u_judge (
        .en          (pwm_en),
        .armed       (s_q.armed),
        .shdn        (s_q.shdn),
        .rise        (rise),
        .fall        (fall),
        .ended_ticks (ended_ticks),
        .bad_pulse   (bad_pulse)
    );

    pwmdim_gate u_gate (
        .main_req     (main_req),
        .pwm_en       (pwm_en),
        .armed        (s_d.armed),
        .level        (pwm_in),
        .shdn         (s_d.shdn),
        .main_on_next (main_on_next)
    );

    always_comb begin
        s_d       = s_q;
        s_d.live  = 1'b1;
        s_d.viol  = s_q.viol | bad_pulse;
        if (!pwm_en) begin
            s_d.armed = 1'b0;
            s_d.shdn  = 1'b0;
        end else if (rise) begin
            s_d.armed = 1'b1;
            s_d.shdn  = 1'b0;
        end else if (s_q.armed && !fall && !pwm_in && run_ticks >= SHDN_LIM) begin
            s_d.shdn  = 1'b1;
        end
        s_d.main_on = main_on_next;
        s_d.sub_on  = sub_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= CTL_RESET;
        else        s_q <= s_d;
    end

    assign main_on   = s_q.main_on;
    assign sub_on    = s_q.sub_on;
    assign shutdown  = s_q.shdn;
    assign violation = s_q.viol;

    assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.live && $past(!pwm_en) |-> main_on == $past(main_req));

    assert_sub_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.live |-> sub_on == $past(sub_req));

    assert_shdn_blocks_main_R9: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> !main_on);

    assert_rise_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_in) |=> !shutdown);

    assert_viol_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.live && $past(violation) |-> violation);

endmodule

// File: tb/pwm_dim_gate_bench.sv
`timescale 1ns/1ps
module pwm_dim_gate_bench;

    localparam int DIV   = 3;
    localparam int HMIN  = 2;
    localparam int LMIN  = 2;
    localparam int LMAX  = 8;
    localparam int SHDN  = 20;
    localparam int SHDNC = SHDN * DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_en = 1'b0, main_req = 1'b0, sub_req = 1'b0, pwm_in = 1'b0;
    logic main_on, sub_on, shutdown, violation;

    int checks = 0, errors = 0;
    bit finished = 0;

    bit m_armed, m_shdn, m_viol, cur_level;
    int prev_len;

    always #2.5 clk = ~clk;

    pwm_dim_gate #(
        .TICK_DIV(DIV), .HIGH_MIN_TICKS(HMIN), .LOW_MIN_TICKS(LMIN),
        .LOW_MAX_TICKS(LMAX), .SHDN_TICKS(SHDN)
    ) u_pwm_dim_gate (
        .clk(clk), .rst_n(rst_n), .pwm_en(pwm_en), .main_req(main_req),
        .sub_req(sub_req), .pwm_in(pwm_in), .main_on(main_on), .sub_on(sub_on),
        .shutdown(shutdown), .violation(violation)
    );

    function automatic bit high_bad(int len);
        return (len / DIV) < HMIN;
    endfunction

    function automatic bit low_bad(int len);
        return ((len / DIV) < LMIN) || ((len / DIV) > LMAX);
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
        end
    endtask

    // R12: hold reset, check the reset state, release and reset the model
    task automatic do_reset();
        rst_n  = 1'b0;
        pwm_in = 1'b0;
        repeat (3) @(negedge clk);
        chk(main_on,   1'b0, "R12 main_on");
        chk(sub_on,    1'b0, "R12 sub_on");
        chk(shutdown,  1'b0, "R12 shutdown");
        chk(violation, 1'b0, "R12 violation");
        rst_n = 1'b1;
        m_armed = 0; m_shdn = 0; m_viol = 0; cur_level = 1; prev_len = 0;
    endtask

    task automatic phase(input logic lvl, input int n, input string tag);
        bit edge_seen;
        bit sd;
        int base;
        edge_seen = (lvl != cur_level);
        if (!pwm_en) begin
            m_armed = 0; m_shdn = 0;
        end else if (edge_seen) begin
            if (lvl) begin
                if (m_armed && !m_shdn && low_bad(prev_len)) m_viol = 1;
                m_armed = 1; m_shdn = 0;
            end else if (m_armed && high_bad(prev_len)) begin
                m_viol = 1;
            end
        end
        base = edge_seen ? 0 : prev_len;
        pwm_in = lvl;
        cur_level = lvl;
        sd = m_shdn;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            sd = m_shdn | (pwm_en & m_armed & !lvl & ((base + i) >= SHDNC));
            chk(main_on, main_req & (!pwm_en | (m_armed & lvl & !sd)),
                pwm_en ? {tag, " R3 main_on"} : {tag, " R1 main_on"});
            chk(sub_on, sub_req, {tag, " R2 sub_on"});
            chk(shutdown, sd, {tag, " R9 shutdown"});
            chk(violation, m_viol, {tag, " R7 R8 R11 violation"});
        end
        m_shdn = sd;
        prev_len = base + n;
    endtask

    initial begin
        void'($urandom(32'd20240917));
        do_reset();
        // R1: dimming off, pwm pulses ignored, even illegal ones
        main_req = 1; sub_req = 1;
        phase(1, 4, "R1"); phase(0, 3, "R1"); phase(1, 1, "R1"); phase(0, 5, "R1");
        // R4: enable while low, no edge yet, main stays dark
        pwm_en = 1;
        phase(0, 5, "R4");
        // R3 R6: boundaries of the valid windows (6 = shortest high, 6/26 = low limits)
        phase(1, 8, "R3"); phase(0, 10, "R3"); phase(1, 6, "R6"); phase(0, 6, "R6");
        phase(1, 7, "R6"); phase(0, 26, "R6"); phase(1, 9, "R3");
        main_req = 0;
        phase(0, 7, "R3"); phase(1, 7, "R3");
        main_req = 1; sub_req = 0;
        // R5 R4: drop enable while high, then re-enable while high
        pwm_en = 0;
        phase(1, 3, "R5");
        pwm_en = 1;
        phase(1, 5, "R4"); phase(0, 8, "R4"); phase(1, 7, "R4");
        sub_req = 1;
        // R9: one cycle short of the delay, then beyond it
        phase(0, SHDNC - 1, "R9"); phase(1, 7, "R9");
        phase(0, SHDNC + 10, "R9");
        // R10: rising edge clears shutdown, no violation recorded
        phase(1, 7, "R10"); phase(0, 9, "R10");
        // R5: shutdown, then disable clears it
        phase(0, SHDNC, "R5");
        pwm_en = 0;
        phase(0, 3, "R5");
        pwm_en = 1;
        phase(1, 6, "R5"); phase(0, 9, "R5");
        // R7: high of 5 cycles = 1 tick, then R11 stickiness
        phase(1, 5, "R7"); phase(0, 9, "R7"); phase(1, 8, "R11"); phase(0, 9, "R11");
        // R8: low too long but under shutdown
        do_reset();
        pwm_en = 1;
        phase(0, 4, "R11"); phase(1, 7, "R11"); phase(0, 27, "R8"); phase(1, 7, "R8");
        // R8: low too short
        do_reset();
        phase(0, 4, "R8"); phase(1, 7, "R8"); phase(0, 5, "R8"); phase(1, 7, "R8");
        // random trains
        do_reset();
        for (int k = 0; k < 60; k++) begin
            main_req = 1'($urandom_range(0, 3) != 0);
            sub_req  = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 15) == 0) pwm_en = ~pwm_en;
            phase(~cur_level, cur_level ? $urandom_range(1, 75) : $urandom_range(1, 12), "RND");
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL R12 watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule